// File: doc/BRIEF.md
# Floppy Controller Rate Select Register

This block is the host-side register slice of a floppy disk controller that sets the data rate and the write precompensation. A byte-wide I/O bus reaches it through a 3-bit port offset. Two write-only ports share one data rate field. The rate select port at offset 4 carries the rate, the precompensation select, a low power request and a software reset request. The configuration control port at offset 7 carries only a rate. Whichever of the two ports was written last sets the rate.

The software reset request does not stay stored. It comes out as a pulse one clock wide. Low power mode is entered from the rate select port. It is left after a software reset pulse, or after any access to the data register (offset 5) or any read of the status register (offset 4). A shadow copy of the last rate select write is kept for readback through configuration space. The precompensation select goes out undecoded; the value 0 means the default delay for the selected rate.

Top module: `fdc_rate_regs`

## Requirements
- R1: After the asynchronous reset the outputs are: `rate_o` = 2'b10 (250 Kbps), `precomp_o` = 3'b000, `low_power_o` = 0, `sw_reset_o` = 0 and `shadow_o` = 8'h02.
- R2: A write at offset 4 loads `rate_o` from data bits 1:0 and `precomp_o` from data bits 4:2. Both are visible from the clock cycle after the write.
- R3: A write at offset 7 loads `rate_o` from data bits 1:0. Its bits 7:2 are ignored, and `precomp_o`, `shadow_o` and `low_power_o` keep their values.
- R4: `rate_o` always equals bits 1:0 of the most recent write at offset 4 or offset 7, whatever order the two ports are written in.
- R5: `shadow_o` changes only on writes at offset 4. It then holds the written byte with bit 5 and bit 7 forced to 0.
- R6: A write at offset 4 with bit 7 set drives `sw_reset_o` high for exactly the one cycle after the write. The software reset leaves `rate_o`, `precomp_o` and `shadow_o` unchanged.
- R7: A write at offset 4 with bit 6 set makes `low_power_o` 1 from the next cycle. A later write at offset 4 with bit 6 clear does not end low power.
- R8: `low_power_o` is 0 in the cycle after a `sw_reset_o` pulse. The software reset wins over a low power request made in the same write.
- R9: A read or a write at offset 5, or a read at offset 4, clears `low_power_o` from the next cycle and changes no other output. A read at offset 7 changes nothing.
- R10: When `acc_en_i` is low, no input has any effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| acc_en_i | input | 1 | Bus access strobe, one cycle per access |
| acc_we_i | input | 1 | 1 = write, 0 = read |
| acc_addr_i | input | 3 | Port offset (4 rate select/status, 5 data, 7 config control) |
| acc_wdata_i | input | 8 | Write data |
| rate_o | output | 2 | Effective data rate code |
| precomp_o | output | 3 | Precompensation select, undecoded |
| low_power_o | output | 1 | Manual low power mode active |
| sw_reset_o | output | 1 | Software reset pulse, one cycle |
| shadow_o | output | 8 | Shadow copy of the last rate select write |

## Verification
The software reset pulse and the low power entry can fall in the same cycle, because a single rate select write can set bits 7 and 6 together. The bench provokes this by sweeping all 256 rate select bytes. For bytes with both bits set, it expects `low_power_o` high in the pulse cycle and low in the cycle after. The bench also checks that the rate and precompensation written with the reset byte survive the pulse. A second collision, between the two rate ports, is judged by alternating writes to both ports and expecting the rate of the later write.

// File: rtl/fdc_rate_pkg.sv
package fdc_rate_pkg;
  localparam int unsigned DATA_W   = 8;
  localparam int unsigned ADDR_W   = 3;
  localparam int unsigned RATE_W   = 2;
  localparam int unsigned PCOMP_W  = 3;
  localparam int unsigned PCOMP_LSB = RATE_W;
  localparam int unsigned UNDEF_BIT = PCOMP_LSB + PCOMP_W;
  localparam int unsigned LP_BIT    = UNDEF_BIT + 1;
  localparam int unsigned SRST_BIT  = LP_BIT + 1;
  localparam logic [DATA_W-1:0] RST_VAL = 8'h02;

  localparam logic [ADDR_W-1:0] OFS_RATE_SEL = 3'd4;
  localparam logic [ADDR_W-1:0] OFS_DATA     = 3'd5;
  localparam logic [ADDR_W-1:0] OFS_CFG_CTL  = 3'd7;

  typedef struct packed {
    logic rate_wr;
    logic cfg_wr;
    logic wake;
  } strobe_t;
endpackage

// File: rtl/fdc_bus_decode.sv
module fdc_bus_decode
  import fdc_rate_pkg::*;
(
  input  logic              en_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  output strobe_t           strb_o
);
  logic hit_rate, hit_data, hit_cfg;

  always_comb begin
    hit_rate = (addr_i == OFS_RATE_SEL);
    hit_data = (addr_i == OFS_DATA);
    hit_cfg  = (addr_i == OFS_CFG_CTL);
    strb_o.rate_wr = en_i & we_i & hit_rate;
    strb_o.cfg_wr  = en_i & we_i & hit_cfg;
    // data port in either direction, status port on read
    strb_o.wake    = en_i & (hit_data | (hit_rate & ~we_i));
  end
endmodule

// File: rtl/fdc_rate_store.sv
module fdc_rate_store
  import fdc_rate_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               rate_wr_i,
  input  logic               cfg_wr_i,
  input  logic [DATA_W-1:0]  wdata_i,
  output logic [RATE_W-1:0]  rate_o,
  output logic [PCOMP_W-1:0] precomp_o,
  output logic [DATA_W-1:0]  shadow_o
);
  logic [RATE_W-1:0]  rate_q;
  logic [PCOMP_W-1:0] pcomp_q;
  logic [DATA_W-1:0]  shadow_q;
  logic [DATA_W-1:0]  shadow_d;

  // undefined and self-clearing bits are never stored
  for (genvar i = 0; i < DATA_W; i++) begin : g_mask
    if (i == UNDEF_BIT || i == SRST_BIT) begin : g_zero
      assign shadow_d[i] = 1'b0;
    end else begin : g_keep
      assign shadow_d[i] = wdata_i[i];
    end
  end

  logic unused_wdata;
  assign unused_wdata = ^{wdata_i[UNDEF_BIT], wdata_i[SRST_BIT]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rate_q   <= RST_VAL[RATE_W-1:0];
      pcomp_q  <= RST_VAL[PCOMP_LSB +: PCOMP_W];
      shadow_q <= RST_VAL;
    end else begin
      // rate select port wins if both strobe together
      if (rate_wr_i || cfg_wr_i) rate_q <= wdata_i[RATE_W-1:0];
      if (rate_wr_i) begin
        pcomp_q  <= wdata_i[PCOMP_LSB +: PCOMP_W];
        shadow_q <= shadow_d;
      end
    end
  end

  assign rate_o    = rate_q;
  assign precomp_o = pcomp_q;
  assign shadow_o  = shadow_q;
endmodule

// File: rtl/fdc_power_ctl.sv
module fdc_power_ctl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rate_wr_i,
  input  logic wake_i,
  input  logic srst_req_i,
  input  logic lp_req_i,
  output logic sw_reset_o,
  output logic low_power_o
);
  logic srst_q, lp_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      srst_q <= 1'b0;
      lp_q   <= 1'b0;
    end else begin
      srst_q <= rate_wr_i & srst_req_i;
      if (srst_q || wake_i)          lp_q <= 1'b0;
      else if (rate_wr_i && lp_req_i) lp_q <= 1'b1;
    end
  end

  assign sw_reset_o  = srst_q;
  assign low_power_o = lp_q;
endmodule

// File: rtl/fdc_rate_regs.sv
module fdc_rate_regs
  import fdc_rate_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               acc_en_i,
  input  logic               acc_we_i,
  input  logic [ADDR_W-1:0]  acc_addr_i,
  input  logic [DATA_W-1:0]  acc_wdata_i,
  output logic [RATE_W-1:0]  rate_o,
  output logic [PCOMP_W-1:0] precomp_o,
  output logic               low_power_o,
  output logic               sw_reset_o,
  output logic [DATA_W-1:0]  shadow_o
);
  strobe_t strb;

  fdc_bus_decode u_dec (
    .en_i   (acc_en_i),
    .we_i   (acc_we_i),
    .addr_i (acc_addr_i),
    .strb_o (strb)
  );

  fdc_rate_store u_store (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .rate_wr_i (strb.rate_wr),
    .cfg_wr_i  (strb.cfg_wr),
    .wdata_i   (acc_wdata_i),
    .rate_o    (rate_o),
    .precomp_o (precomp_o),
    .shadow_o  (shadow_o)
  );

  fdc_power_ctl u_pwr (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rate_wr_i   (strb.rate_wr),
    .wake_i      (strb.wake),
    .srst_req_i  (acc_wdata_i[SRST_BIT]),
    .lp_req_i    (acc_wdata_i[LP_BIT]),
    .sw_reset_o  (sw_reset_o),
    .low_power_o (low_power_o)
  );
endmodule

// File: rtl/fdc_rate_regs_chk.sv
module fdc_rate_regs_chk
  import fdc_rate_pkg::*;
(
  input logic               clk_i,
  input logic               rst_ni,
  input logic               acc_en_i,
  input logic               acc_we_i,
  input logic [ADDR_W-1:0]  acc_addr_i,
  input logic [DATA_W-1:0]  acc_wdata_i,
  input logic [RATE_W-1:0]  rate_o,
  input logic [PCOMP_W-1:0] precomp_o,
  input logic               low_power_o,
  input logic               sw_reset_o,
  input logic [DATA_W-1:0]  shadow_o
);
  logic c_rwr, c_cwr, c_wake;
  assign c_rwr  = acc_en_i && acc_we_i && acc_addr_i == 3'd4;
  assign c_cwr  = acc_en_i && acc_we_i && acc_addr_i == 3'd7;
  assign c_wake = acc_en_i && (acc_addr_i == 3'd5 || (acc_addr_i == 3'd4 && !acc_we_i));

  logic unused_b5;
  assign unused_b5 = acc_wdata_i[5];

  a_r2_rate_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    c_rwr |=> rate_o == $past(acc_wdata_i[1:0]) && precomp_o == $past(acc_wdata_i[4:2]));
  a_r3_cfg_rate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (c_cwr && !c_rwr) |=> rate_o == $past(acc_wdata_i[1:0]) && $stable(precomp_o) && $stable(shadow_o));
  a_r10_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!c_rwr && !c_cwr) |=> $stable(rate_o) && $stable(precomp_o) && $stable(shadow_o));
  a_r5_shadow_bits: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !shadow_o[5] && !shadow_o[7]);
  a_r6_pulse_src: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sw_reset_o |-> $past(c_rwr && acc_wdata_i[7]));
  a_r6_pulse_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (c_rwr && acc_wdata_i[7]) |=> sw_reset_o);
  a_r8_lp_exit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sw_reset_o |=> !low_power_o);
  a_r9_wake: assert property (@(posedge clk_i) disable iff (!rst_ni)
    c_wake |=> !low_power_o);
  a_r7_lp_src: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(low_power_o) |-> $past(c_rwr && acc_wdata_i[6]));
endmodule

bind fdc_rate_regs fdc_rate_regs_chk chk_i (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .acc_en_i    (acc_en_i),
  .acc_we_i    (acc_we_i),
  .acc_addr_i  (acc_addr_i),
  .acc_wdata_i (acc_wdata_i),
  .rate_o      (rate_o),
  .precomp_o   (precomp_o),
  .low_power_o (low_power_o),
  .sw_reset_o  (sw_reset_o),
  .shadow_o    (shadow_o)
);

// File: tb/fdc_rate_regs_tb_top.sv
`timescale 1ns/1ps
module fdc_rate_regs_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b0, we = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [1:0] rate;
  logic [2:0] pc;
  logic       lp, sr;
  logic [7:0] sh;

  int n_tests = 0;
  int n_fail  = 0;

  always #2.5 clk = ~clk;

  fdc_rate_regs dut_i (
    .clk_i(clk), .rst_ni(rst_n), .acc_en_i(en), .acc_we_i(we),
    .acc_addr_i(addr), .acc_wdata_i(wdata), .rate_o(rate), .precomp_o(pc),
    .low_power_o(lp), .sw_reset_o(sr), .shadow_o(sh)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // one-cycle access; returns at the negedge after the capturing edge
  task automatic acc(input logic e, input logic w, input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    en = e; we = w; addr = a; wdata = d;
    @(negedge clk);
    en = 1'b0; we = 1'b0; addr = '0; wdata = '0;
  endtask

  task automatic check_all(input string req, input logic [1:0] er, input logic [2:0] ep,
                           input logic el, input logic es, input logic [7:0] esh);
    chk({req, " rate"}, {6'd0, rate}, {6'd0, er});
    chk({req, " precomp"}, {5'd0, pc}, {5'd0, ep});
    chk({req, " low_power"}, {7'd0, lp}, {7'd0, el});
    chk({req, " sw_reset"}, {7'd0, sr}, {7'd0, es});
    chk({req, " shadow"}, sh, esh);
  endtask

  initial begin
    #100000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [2:0] last_pc;
    logic [7:0] last_sh;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_all("R1 reset", 2'b10, 3'b000, 1'b0, 1'b0, 8'h02);

    // R2 R5 R6 R7 R8 R9: sweep every rate select byte
    for (int v = 0; v < 256; v++) begin
      logic [7:0] b;
      b = v[7:0];
      acc(1, 1, 3'd4, b);
      check_all("R2/R5/R6/R7 write", b[1:0], b[4:2], b[6], b[7], b & 8'h5F);
      @(negedge clk);
      check_all("R6/R8 after pulse", b[1:0], b[4:2], b[6] & ~b[7], 1'b0, b & 8'h5F);
      acc(1, 0, 3'd4, 8'h00);
      check_all("R9 status read", b[1:0], b[4:2], 1'b0, 1'b0, b & 8'h5F);
    end

    // R3 R4: sweep every config control byte, interleaved with rate select
    acc(1, 1, 3'd4, 8'h14);
    last_pc = 3'b101; last_sh = 8'h14;
    for (int v = 0; v < 256; v++) begin
      logic [7:0] b;
      b = v[7:0];
      acc(1, 1, 3'd7, b);
      check_all("R3 cfg write", b[1:0], last_pc, 1'b0, 1'b0, last_sh);
      acc(1, 1, 3'd4, {3'b000, b[2:0], ~b[1:0]});
      last_pc = b[2:0]; last_sh = {3'b000, b[2:0], ~b[1:0]};
      check_all("R4 rate sel after cfg", ~b[1:0], last_pc, 1'b0, 1'b0, last_sh);
      acc(1, 1, 3'd7, {6'd0, b[3:2]});
      chk("R4 cfg after rate sel", {6'd0, rate}, {6'd0, b[3:2]});
    end

    // R7: bit 6 clear does not end low power
    acc(1, 1, 3'd4, 8'h40);
    chk("R7 enter", {7'd0, lp}, 8'd1);
    acc(1, 1, 3'd4, 8'h01);
    check_all("R7 stays", 2'b01, 3'b000, 1'b1, 1'b0, 8'h01);
    // R9: read of offset 7 ignored, data write wakes
    acc(1, 0, 3'd7, 8'hFF);
    check_all("R9 cfg read ignored", 2'b01, 3'b000, 1'b1, 1'b0, 8'h01);
    acc(1, 1, 3'd5, 8'hAA);
    check_all("R9 data write", 2'b01, 3'b000, 1'b0, 1'b0, 8'h01);
    acc(1, 1, 3'd4, 8'h4E);
    chk("R7 enter again", {7'd0, lp}, 8'd1);
    acc(1, 0, 3'd5, 8'h00);
    check_all("R9 data read", 2'b10, 3'b011, 1'b0, 1'b0, 8'h4E);

    // R10: disabled accesses at every offset
    acc(1, 1, 3'd4, 8'h40);
    for (int a = 0; a < 8; a++) begin
      acc(0, 1, a[2:0], 8'hC3);
      acc(0, 0, a[2:0], 8'h00);
      check_all("R10 disabled", 2'b00, 3'b000, 1'b1, 1'b0, 8'h40);
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule